// File: doc/BRIEF.md
# Pipelined ADC Digital Correction

This block is the digital back end of a pipelined analog-to-digital converter. Each conversion clock it receives one raw code from each of ten stage quantizers: a 4-bit first stage, eight 1.5-bit stages and a 3-bit closing flash. A stage works on a sample one clock after the stage in front of it. The block therefore delays each stage's code by a different number of clocks, so that all ten codes of one sample reach the adder in the same cycle.

The aligned codes are summed with one bit of overlap between neighbouring stages, and a fixed mid-scale bias is removed. This cancels comparator decision errors in the earlier stages. The 14-bit corrected value is cut to a 12-bit word. Values outside full scale saturate and raise a range flag. The word can be shown as offset binary or as two's complement. A valid flag goes high once the pipeline has filled after reset. A power-down input drops the output-drive enable.

Top module: `adc_corr_top`

## Requirements
- R1: The inputs are `first_code` (4 bits), `mid_codes` (1.5-bit stage k, where k=0 is the stage right after the first, at bits [2k+1:2k]) and `flash_code` (3 bits). For a sample whose first code is present in cycle t, stage k's code is present in cycle t+1+k and the flash code in cycle t+9.
- R2: The corrected value is V = first*1024 + sum over k of mid_k*2^(9-k) + flash - 1020. When 0 <= V <= 16383, `data_out` in offset binary equals V>>2 (bits 13:2 of V) and `out_range` is 0.
- R3: A 1.5-bit stage code of 3 is counted as 2.
- R4: When V > 16383, the offset-binary output is 4095 and `out_range` is 1.
- R5: When V < 0, the offset-binary output is 0 and `out_range` is 1.
- R6: With `fmt_twos`=1, `data_out` is the offset-binary word with bit 11 inverted. The select acts on the word already held, without a clock.
- R7: A sample's result appears on `data_out` just after the 10th rising edge, counting the edge that captured its first-stage code as the first.
- R8: `out_valid` is 0 during reset. It rises just after the 10th rising edge that follows reset release and then stays at 1.
- R9: `out_drive_en` equals the inverse of `power_down`. Power-down does not disturb the pipeline or the results.
- R10: A synchronous active-high `rst` clears the delay registers, the output word (to 0), `out_range` and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| first_code | input | 4 | Raw code of the first stage |
| mid_codes | input | 16 | Raw 2-bit codes of the eight 1.5-bit stages |
| flash_code | input | 3 | Raw code of the closing flash |
| fmt_twos | input | 1 | 1 selects two's complement output |
| power_down | input | 1 | 1 deasserts the output-drive enable |
| data_out | output | 12 | Corrected word |
| out_range | output | 1 | Input beyond full scale |
| out_valid | output | 1 | Pipeline filled since reset |
| out_drive_en | output | 1 | Output buffers enabled |

## Verification
The scoreboard feeds skewed stage codes and expects each result exactly ten edges after its first code. A delay line one stage too short or too long mixes codes from neighbouring samples, and the popped values then mismatch. Codes of 3 in the 1.5-bit stages catch a design that uses the illegal value as 3. The bench also drives V at 16383, 16387, 0, -4 and 3. These catch an off-by-one saturation threshold, a wrong truncation, and an overflow or underflow that wraps instead of saturating. Toggling the format select and power-down in the middle of a stream exposes an MSB inversion that is registered or applied in the wrong place. It also exposes an enable that stalls the pipeline.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;

    localparam int unsigned DEF_MID_STAGES = 8;
    localparam int unsigned DEF_FIRST_W    = 4;
    localparam int unsigned DEF_FLASH_W    = 3;
    localparam int unsigned DEF_OUT_W      = 12;

    typedef enum logic [1:0] {
        RNG_OK   = 2'd0,
        RNG_LOW  = 2'd1,
        RNG_HIGH = 2'd2
    } rng_e;

    // Map an illegal 1.5-bit decision (3) onto the top legal value.
    function automatic logic [1:0] mid_legal(input logic [1:0] c);
        return (c == 2'd3) ? 2'd2 : c;
    endfunction

    // Bits of corrected resolution: first stage loses one redundant bit.
    function automatic int unsigned corr_width(input int unsigned fw,
                                               input int unsigned nm,
                                               input int unsigned lw);
        return fw - 1 + nm + lw;
    endfunction

    // Weight exponent of 1.5-bit stage k (k = 0 nearest the first stage).
    function automatic int unsigned mid_shift(input int unsigned k,
                                              input int unsigned nm,
                                              input int unsigned lw);
        return lw - 1 + nm - 1 - k;
    endfunction

    // Sum of the mid-code (value 1) weights of all 1.5-bit stages.
    function automatic int unsigned mid_bias(input int unsigned nm,
                                             input int unsigned lw);
        return (2 ** (lw - 1)) * ((2 ** nm) - 1);
    endfunction

endpackage

// File: rtl/adc_corr_delay.sv
module adc_corr_delay #(
    parameter int unsigned WIDTH = 2,
    parameter int unsigned DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] pipe [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                pipe[i] <= '0;
            end
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < int'(DEPTH); i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[DEPTH-1];

endmodule

// File: rtl/adc_corr_combine.sv
module adc_corr_combine
    import adc_corr_pkg::*;
#(
    parameter int unsigned N_MID   = DEF_MID_STAGES,
    parameter int unsigned FIRST_W = DEF_FIRST_W,
    parameter int unsigned FLASH_W = DEF_FLASH_W,
    parameter int unsigned OUT_W   = DEF_OUT_W
) (
    input  logic [FIRST_W-1:0] first_al,
    input  logic [2*N_MID-1:0] mid_al,
    input  logic [FLASH_W-1:0] flash_al,
    output logic [OUT_W-1:0]   code,
    output rng_e               rng
);

    localparam int unsigned CORR_W   = corr_width(FIRST_W, N_MID, FLASH_W);
    localparam int unsigned SUM_W    = CORR_W + 3;
    localparam int unsigned FIRST_SH = FLASH_W - 1 + N_MID;
    localparam logic signed [SUM_W-1:0] BIAS_S = SUM_W'(mid_bias(N_MID, FLASH_W));
    localparam logic signed [SUM_W-1:0] TOP_S  = SUM_W'((2 ** CORR_W) - 1);

    logic signed [SUM_W-1:0] acc;

    always_comb begin
        acc = $signed({{(SUM_W-FIRST_W){1'b0}}, first_al}) <<< FIRST_SH;
        for (int unsigned k = 0; k < N_MID; k++) begin
            acc = acc + ($signed({{(SUM_W-2){1'b0}}, mid_legal(mid_al[2*k +: 2])})
                         <<< mid_shift(k, N_MID, FLASH_W));
        end
        acc = acc + $signed({{(SUM_W-FLASH_W){1'b0}}, flash_al});
        acc = acc - BIAS_S;
    end

    always_comb begin
        if (acc < 0) begin
            rng  = RNG_LOW;
            code = '0;
        end else if (acc > TOP_S) begin
            rng  = RNG_HIGH;
            code = '1;
        end else begin
            rng  = RNG_OK;
            code = acc[CORR_W-1 -: OUT_W];
        end
    end

endmodule

// File: rtl/adc_corr_out.sv
module adc_corr_out
    import adc_corr_pkg::*;
#(
    parameter int unsigned OUT_W = DEF_OUT_W,
    parameter int unsigned LAT   = DEF_MID_STAGES + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OUT_W-1:0] code_in,
    input  rng_e             rng_in,
    input  logic             fmt_twos,
    input  logic             power_down,
    output logic [OUT_W-1:0] data_out,
    output logic             out_range,
    output logic             out_valid,
    output logic             out_drive_en
);

    localparam int unsigned CNT_W = $clog2(LAT + 1);

    typedef struct packed {
        logic [OUT_W-1:0] code;
        rng_e             rng;
    } result_t;

    result_t          res_q;
    logic [CNT_W-1:0] fill_cnt;
    logic             valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q    <= '{code: '0, rng: RNG_OK};
            fill_cnt <= '0;
            valid_q  <= 1'b0;
        end else begin
            res_q <= '{code: code_in, rng: rng_in};
            if (!valid_q) begin
                fill_cnt <= fill_cnt + 1'b1;
            end
            if (fill_cnt == CNT_W'(LAT - 1)) begin
                valid_q <= 1'b1;
            end
        end
    end

    assign data_out     = res_q.code ^ {fmt_twos, {(OUT_W-1){1'b0}}};
    assign out_range    = (res_q.rng != RNG_OK);
    assign out_valid    = valid_q;
    assign out_drive_en = !power_down;

endmodule

// File: rtl/adc_corr_top.sv
module adc_corr_top
    import adc_corr_pkg::*;
#(
    parameter int unsigned N_MID   = DEF_MID_STAGES,
    parameter int unsigned FIRST_W = DEF_FIRST_W,
    parameter int unsigned FLASH_W = DEF_FLASH_W,
    parameter int unsigned OUT_W   = DEF_OUT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [FIRST_W-1:0] first_code,
    input  logic [2*N_MID-1:0] mid_codes,
    input  logic [FLASH_W-1:0] flash_code,
    input  logic               fmt_twos,
    input  logic               power_down,
    output logic [OUT_W-1:0]   data_out,
    output logic               out_range,
    output logic               out_valid,
    output logic               out_drive_en
);

    // First code waits for every later stage plus the flash.
    localparam int unsigned FIRST_DLY = N_MID + 1;
    localparam int unsigned LATENCY   = FIRST_DLY + 1;

    logic [FIRST_W-1:0] first_al;
    logic [2*N_MID-1:0] mid_al;
    logic [OUT_W-1:0]   comb_code;
    rng_e               comb_rng;

    adc_corr_delay #(
        .WIDTH (FIRST_W),
        .DEPTH (FIRST_DLY)
    ) u_first_dly (
        .clk (clk),
        .rst (rst),
        .d   (first_code),
        .q   (first_al)
    );

    for (genvar k = 0; k < int'(N_MID); k++) begin : g_mid
        adc_corr_delay #(
            .WIDTH (2),
            .DEPTH (N_MID - k)
        ) u_mid_dly (
            .clk (clk),
            .rst (rst),
            .d   (mid_codes[2*k +: 2]),
            .q   (mid_al[2*k +: 2])
        );
    end

    adc_corr_combine #(
        .N_MID   (N_MID),
        .FIRST_W (FIRST_W),
        .FLASH_W (FLASH_W),
        .OUT_W   (OUT_W)
    ) u_combine (
        .first_al (first_al),
        .mid_al   (mid_al),
        .flash_al (flash_code),
        .code     (comb_code),
        .rng      (comb_rng)
    );

    adc_corr_out #(
        .OUT_W (OUT_W),
        .LAT   (LATENCY)
    ) u_out (
        .clk          (clk),
        .rst          (rst),
        .code_in      (comb_code),
        .rng_in       (comb_rng),
        .fmt_twos     (fmt_twos),
        .power_down   (power_down),
        .data_out     (data_out),
        .out_range    (out_range),
        .out_valid    (out_valid),
        .out_drive_en (out_drive_en)
    );

endmodule

// File: rtl/adc_corr_chk.sv
module adc_corr_chk #(
    parameter int unsigned OUT_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             fmt_twos,
    input logic [OUT_W-1:0] data_out,
    input logic             out_range,
    input logic             out_valid
);

    // R4: a high out-of-range word in offset binary is all ones
    a_r4_high_sat: assert property (@(posedge clk) disable iff (rst)
        (out_range && !fmt_twos && data_out[OUT_W-1]) |-> (data_out == '1));

    // R5: a low out-of-range word in offset binary is all zeros
    a_r5_low_sat: assert property (@(posedge clk) disable iff (rst)
        (out_range && !fmt_twos && !data_out[OUT_W-1]) |-> (data_out == '0));

    // R6: in two's complement a saturated word is the most positive or most negative value
    a_r6_twos_otr: assert property (@(posedge clk) disable iff (rst)
        (out_range && fmt_twos) |->
        ((data_out == {1'b0, {(OUT_W-1){1'b1}}}) || (data_out == {1'b1, {(OUT_W-1){1'b0}}})));

    // R8: once valid, stays valid until reset
    a_r8_valid_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> out_valid);

    // R10: reset clears the valid and range flags
    a_r10_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_range));

endmodule

bind adc_corr_top adc_corr_chk #(
    .OUT_W (OUT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fmt_twos  (fmt_twos),
    .data_out  (data_out),
    .out_range (out_range),
    .out_valid (out_valid)
);

// File: tb/adc_corr_top_tb.sv
module adc_corr_top_tb;

    localparam int N_MID = 8;
    localparam int NS    = 48;
    localparam int LAT   = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  first_code = '0;
    logic [15:0] mid_codes  = '0;
    logic [2:0]  flash_code = '0;
    logic        fmt_twos   = 1'b0;
    logic        power_down = 1'b0;
    logic [11:0] data_out;
    logic        out_range;
    logic        out_valid;
    logic        out_drive_en;

    always #10 clk = ~clk;

    adc_corr_top u_dut (
        .clk          (clk),
        .rst          (rst),
        .first_code   (first_code),
        .mid_codes    (mid_codes),
        .flash_code   (flash_code),
        .fmt_twos     (fmt_twos),
        .power_down   (power_down),
        .data_out     (data_out),
        .out_range    (out_range),
        .out_valid    (out_valid),
        .out_drive_en (out_drive_en)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        int    code;
        bit    otr;
        string tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [3:0]  fa [NS];
    logic [15:0] ma [NS];
    logic [2:0]  la [NS];
    string       ta [NS];

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Reference model written from R2..R5
    task automatic model(input logic [3:0] f, input logic [15:0] m, input logic [2:0] l,
                         output int code, output bit otr);
        int v;
        v = int'(f) * 1024 + int'(l) - 1020;
        for (int k = 0; k < N_MID; k++) begin
            int e;
            e = (m[2*k +: 2] == 2'd3) ? 2 : int'(m[2*k +: 2]);
            v = v + e * (1 << (9 - k));
        end
        if (v < 0) begin
            code = 0; otr = 1'b1;
        end else if (v > 16383) begin
            code = 4095; otr = 1'b1;
        end else begin
            code = v / 4; otr = 1'b0;
        end
    endtask

    task automatic set_s(input int i, input logic [3:0] f, input logic [15:0] m,
                         input logic [2:0] l, input string tag);
        fa[i] = f; ma[i] = m; la[i] = l; ta[i] = tag;
    endtask

    // Driver: skewed stage codes per R1, expected result pushed to the scoreboard
    task automatic drive_cycle(input int c);
        first_code = (c < NS) ? fa[c] : 4'd0;
        for (int k = 0; k < N_MID; k++) begin
            int idx;
            idx = c - 1 - k;
            mid_codes[2*k +: 2] = (idx >= 0 && idx < NS) ? ma[idx][2*k +: 2] : 2'd1;
        end
        begin
            int fidx;
            fidx = c - 1 - N_MID;
            flash_code = (fidx >= 0 && fidx < NS) ? la[fidx] : 3'd0;
        end
        if (c < NS) begin
            exp_t e;
            model(fa[c], ma[c], la[c], e.code, e.otr);
            e.tag = ta[c];
            sb_q.push_back(e);
        end
    endtask

    // Monitor: pops one expectation per valid output (R7 alignment)
    always @(negedge clk) begin
        #1;
        if (!rst && out_valid && sb_q.size() > 0 && !done) begin
            exp_t e;
            int   want;
            e = sb_q.pop_front();
            want = fmt_twos ? (e.code ^ 2048) : e.code;
            check(data_out == 12'(want), e.tag, "data_out", int'(data_out), want);
            check(out_range == e.otr, e.tag, "out_range", int'(out_range), int'(e.otr));
            check(out_drive_en == !power_down, "R9", "out_drive_en",
                  int'(out_drive_en), int'(!power_down));
        end
    end

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        #(20 * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL R7 watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] lf;
        // Corner samples
        set_s(0, 4'd1,  {8{2'd1}}, 3'd0, "R2");               // V=1024 -> 256
        set_s(1, 4'd2,  {8{2'd3}}, 3'd3, "R3");               // 3 seen as 2: V=3071 -> 767
        set_s(2, 4'd15, {8{2'd2}}, 3'd7, "R4");               // V=16387 -> 4095, otr
        set_s(3, 4'd15, {8{2'd2}}, 3'd3, "R4");               // V=16383 -> 4095, no otr
        set_s(4, 4'd0,  {8{2'd1}}, 3'd0, "R5");               // V=0 -> 0, no otr
        set_s(5, 4'd0,  {2'd0, {7{2'd1}}}, 3'd0, "R5");       // V=-4 -> 0, otr
        set_s(6, 4'd0,  {8{2'd0}}, 3'd0, "R5");               // V=-1020 -> otr
        set_s(7, 4'd0,  {8{2'd1}}, 3'd3, "R2");               // V=3 -> 0 (truncation)
        set_s(8, 4'd0,  {8{2'd1}}, 3'd7, "R2");               // V=7 -> 1
        set_s(9, 4'd8,  {2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd2}, 3'd5, "R1");
        lf = 16'hACE1;
        for (int i = 10; i < NS; i++) begin
            logic [3:0] f;
            f  = lf[3:0];
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            set_s(i, f, lf, lf[6:4], "R1");
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        end

        // R10 / R8: reset state
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(data_out == 12'd0, "R10", "data_out in reset", int'(data_out), 0);
        check(out_range == 1'b0, "R10", "out_range in reset", int'(out_range), 0);
        check(out_valid == 1'b0, "R8", "out_valid in reset", int'(out_valid), 0);

        rst = 1'b0;
        for (int c = 0; c <= NS + N_MID; c++) begin
            // R8: valid rises after the 10th edge since reset release
            if (c <= LAT + 2) begin
                check(out_valid == (c >= LAT), "R8", "out_valid timing",
                      int'(out_valid), int'(c >= LAT));
            end
            // R6: format select mid-stream; R9: power-down mid-stream
            if (c == 20) fmt_twos = 1'b1;
            if (c == 32) fmt_twos = 1'b0;
            if (c == 25) power_down = 1'b1;
            if (c == 29) power_down = 1'b0;
            drive_cycle(c);
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
        #2;
        // R7: every expected result was produced in order
        check(sb_q.size() == 0, "R7", "scoreboard drained", sb_q.size(), 0);
        // R6: format select acts on held word without a clock
        begin
            logic [11:0] held;
            held = data_out;
            fmt_twos = ~fmt_twos;
            #1;
            check(data_out == (held ^ 12'h800), "R6", "comb MSB flip",
                  int'(data_out), int'(held ^ 12'h800));
            fmt_twos = ~fmt_twos;
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule